// File: doc/BRIEF.md
# Hardwired Instruction-Cycle Sequencer

This block is a fixed-logic controller for a small accumulator machine. It steps through four kinds of cycle: instruction fetch, an optional operand-indirection cycle, the execute cycle for the decoded opcode, and an optional interrupt-entry cycle. Each state lasts one clock. In each state the controller raises register-transfer enables for the program counter, the memory address register, the memory buffer register, the instruction register and one accumulator, plus memory read and write strobes. A minimal datapath and a word-addressed memory are included so the controller can be exercised on its own.

Memory contents are placed through a valid/ready load port before the machine starts. A word transfers on a clock edge where `ld_valid` and `ld_ready` are both high. `ld_ready` is high only while the machine is idle and `run` is low. Once `run` is seen high the machine starts fetching at the current program counter. From then on `ld_ready` stays low and the load port is closed until reset. Interrupt requests are plain level inputs. Memory traffic and the register values are visible as plain outputs.

Instruction word layout: opcode in bits [15:12], indirection flag in bit 11, operand address in bits [10:0]. Memory holds 2048 16-bit words. The read value is captured into the buffer register at the end of the read step.

Top module: `icyc_core`

## Requirements
- R1: While reset is asserted and immediately after reset, `pc`, `ir`, `r1` and `ie` are zero, `cyc` is 0, and both memory strobes are low.
- R2: A load word is written when `ld_valid` and `ld_ready` are high on the same edge. `ld_ready` is high only before the first edge where `run` is high, and drops after that edge. Neither memory strobe is raised while `ld_ready` is high.
- R3: Fetch takes three steps. Step 1 copies PC into MAR. Step 2 raises `mem_rd`, loads MBR from memory and adds one to PC in the same step. Step 3 copies MBR into IR. The next cycle is indirection when bit 11 of the fetched word is 1, and execute otherwise.
- R4: Indirection takes three steps. Step 1 loads MAR from IR[10:0]. Step 2 reads memory into MBR. Step 3 replaces IR[10:0] with MBR[10:0] and keeps the opcode. Execute then uses the new address.
- R5: Opcode 4'h1 (add) takes three steps: MAR is loaded from the address, memory is read into MBR, then R1 becomes R1 plus MBR, modulo 2^16.
- R6: Opcode 4'h2 (increment and skip on zero) takes four steps: address, read, MBR plus one, then MBR is written back to the same address. In that last step PC gains one more if the incremented value is zero.
- R7: Opcode 4'h3 (branch and save) takes three steps. Step 1: MAR gets the address and MBR gets PC. Step 2: MBR is written to that address and PC gets the address. Step 3: PC is incremented, so execution continues at address plus one.
- R8: Opcode 4'h4 sets the interrupt enable `ie` in its single execute step. Every other opcode executes as a one-step no-op and returns to fetch.
- R9: A pending `irq` is taken only if `ie` was already 1 in the final execute step. Entry takes three steps: MBR gets PC, then MAR gets 0, PC gets 1 and `ie` clears, then MBR is written to address 0. Fetch follows.
- R10: `cyc` reports the cycle kind: 0 fetch or idle, 1 indirection, 2 execute, 3 interrupt. `mem_wr` is high only in the write steps of R6, R7 and R9. During a write, `mem_addr` shows MAR and `mem_wdata` shows MBR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Start request; sampled while idle |
| ld_valid | input | 1 | Load word valid |
| ld_ready | output | 1 | Load port accepts a word |
| ld_addr | input | 11 | Load word address |
| ld_data | input | 16 | Load word data |
| irq | input | 1 | Level interrupt request |
| mem_rd | output | 1 | Memory read strobe for the current step |
| mem_wr | output | 1 | Memory write strobe for the current step |
| mem_addr | output | 11 | Memory address register |
| mem_wdata | output | 16 | Memory buffer register (write data) |
| cyc | output | 2 | Current cycle kind |
| pc | output | 11 | Program counter |
| ir | output | 16 | Instruction register |
| r1 | output | 16 | Accumulator |
| ie | output | 1 | Interrupt enable |

## Verification
The test program covers the skip on zero twice: once where the increment wraps to zero and the next word must be skipped, and once where it does not. A design that tests the value before the increment, or skips in the wrong step, leaves the accumulator off by one addend. The request line is held high from the start, so an interrupt taken before the enable opcode, or in the enable opcode's own final step, would write the wrong return address to word 0. The handler re-runs the branch-and-save and the indirect add. This catches a saved PC that is off by one and an indirection that overwrites the opcode bits. The request stays low after the first entry, so any second entry shows up as an extra write to word 0.

// File: rtl/icyc_pkg.sv
package icyc_pkg;

  typedef enum logic [4:0] {
    S_IDLE,
    S_F1, S_F2, S_F3,
    S_N1, S_N2, S_N3,
    S_A1, S_A2, S_A3,
    S_Z1, S_Z2, S_Z3, S_Z4,
    S_B1, S_B2, S_B3,
    S_E1,
    S_X1,
    S_V1, S_V2, S_V3
  } state_t;

  typedef enum logic [1:0] {
    CY_FETCH = 2'd0,
    CY_INDIR = 2'd1,
    CY_EXEC  = 2'd2,
    CY_INTR  = 2'd3
  } cyc_t;

  localparam logic [3:0] OP_ADD = 4'h1;
  localparam logic [3:0] OP_ISZ = 4'h2;
  localparam logic [3:0] OP_BSA = 4'h3;
  localparam logic [3:0] OP_ION = 4'h4;

  // Register-transfer enables for one step
  typedef struct packed {
    logic mar_pc;
    logic mar_ir;
    logic mar_save;
    logic mbr_mem;
    logic mbr_pc;
    logic mbr_inc;
    logic ir_all;
    logic ir_addr;
    logic pc_inc;
    logic pc_inc_z;
    logic pc_ir;
    logic pc_hdl;
    logic r1_add;
    logic ie_set;
    logic ie_clr;
    logic mem_rd;
    logic mem_wr;
  } ctl_t;

  function automatic cyc_t cyc_of(state_t s);
    case (s)
      S_N1, S_N2, S_N3:                  return CY_INDIR;
      S_A1, S_A2, S_A3, S_Z1, S_Z2, S_Z3,
      S_Z4, S_B1, S_B2, S_B3, S_E1, S_X1: return CY_EXEC;
      S_V1, S_V2, S_V3:                  return CY_INTR;
      default:                           return CY_FETCH;
    endcase
  endfunction

  function automatic state_t exec_entry(logic [3:0] op);
    case (op)
      OP_ADD:  return S_A1;
      OP_ISZ:  return S_Z1;
      OP_BSA:  return S_B1;
      OP_ION:  return S_E1;
      default: return S_X1;
    endcase
  endfunction

  function automatic logic exec_last(state_t s);
    return (s == S_A3) || (s == S_Z4) || (s == S_B3) || (s == S_E1) || (s == S_X1);
  endfunction

endpackage

// File: rtl/icyc_ram.sv
module icyc_ram #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rword
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  // Captured by the buffer register at the end of the read step
  assign rword = cells[raddr];

endmodule

// File: rtl/icyc_seq.sv
module icyc_seq
  import icyc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       irq,
  input  logic       ie,
  input  logic [3:0] mbr_op,
  input  logic       mbr_ind,
  input  logic [3:0] ir_op,
  output state_t     state,
  output ctl_t       ctl
);
  state_t nxt;
  logic   take_int;

  assign take_int = irq && ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
  end

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE: if (run) nxt = S_F1;
      S_F1:   nxt = S_F2;
      S_F2:   nxt = S_F3;
      S_F3:   nxt = mbr_ind ? S_N1 : exec_entry(mbr_op);
      S_N1:   nxt = S_N2;
      S_N2:   nxt = S_N3;
      S_N3:   nxt = exec_entry(ir_op);
      S_A1:   nxt = S_A2;
      S_A2:   nxt = S_A3;
      S_Z1:   nxt = S_Z2;
      S_Z2:   nxt = S_Z3;
      S_Z3:   nxt = S_Z4;
      S_B1:   nxt = S_B2;
      S_B2:   nxt = S_B3;
      S_V1:   nxt = S_V2;
      S_V2:   nxt = S_V3;
      S_V3:   nxt = S_F1;
      default: nxt = S_IDLE;
    endcase
    if (exec_last(state)) nxt = take_int ? S_V1 : S_F1;
  end

  always_comb begin
    ctl = '0;
    case (state)
      S_F1: ctl.mar_pc = 1'b1;
      S_F2: begin ctl.mbr_mem = 1'b1; ctl.mem_rd = 1'b1; ctl.pc_inc = 1'b1; end
      S_F3: ctl.ir_all = 1'b1;
      S_N1, S_A1, S_Z1: ctl.mar_ir = 1'b1;
      S_N2, S_A2, S_Z2: begin ctl.mbr_mem = 1'b1; ctl.mem_rd = 1'b1; end
      S_N3: ctl.ir_addr = 1'b1;
      S_A3: ctl.r1_add = 1'b1;
      S_Z3: ctl.mbr_inc = 1'b1;
      S_Z4: begin ctl.mem_wr = 1'b1; ctl.pc_inc_z = 1'b1; end
      S_B1: begin ctl.mar_ir = 1'b1; ctl.mbr_pc = 1'b1; end
      S_B2: begin ctl.mem_wr = 1'b1; ctl.pc_ir = 1'b1; end
      S_B3: ctl.pc_inc = 1'b1;
      S_E1: ctl.ie_set = 1'b1;
      S_V1: ctl.mbr_pc = 1'b1;
      S_V2: begin ctl.mar_save = 1'b1; ctl.pc_hdl = 1'b1; ctl.ie_clr = 1'b1; end
      S_V3: ctl.mem_wr = 1'b1;
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/icyc_dpath.sv
module icyc_dpath
  import icyc_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 11,
  parameter int SAVE_ADDR = 0,
  parameter int HDL_ADDR  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_t              ctl,
  input  logic [DATA_W-1:0] rword,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] mar,
  output logic [DATA_W-1:0] mbr,
  output logic [DATA_W-1:0] ir,
  output logic [DATA_W-1:0] r1,
  output logic              ie,
  output logic              mbr_zero
);
  localparam int PAD_W = DATA_W - ADDR_W;
  localparam logic [ADDR_W-1:0] SAVE_A = ADDR_W'(SAVE_ADDR);
  localparam logic [ADDR_W-1:0] HDL_A  = ADDR_W'(HDL_ADDR);

  logic [ADDR_W-1:0] ir_a;
  logic              pc_bump;

  assign ir_a     = ir[ADDR_W-1:0];
  assign mbr_zero = (mbr == '0);
  assign pc_bump  = ctl.pc_inc || (ctl.pc_inc_z && mbr_zero);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else if (ctl.pc_hdl) pc <= HDL_A;
    else if (ctl.pc_ir)  pc <= ir_a;
    else if (pc_bump)    pc <= pc + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mar <= '0;
    else if (ctl.mar_pc)   mar <= pc;
    else if (ctl.mar_ir)   mar <= ir_a;
    else if (ctl.mar_save) mar <= SAVE_A;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mbr <= '0;
    else if (ctl.mbr_mem) mbr <= rword;
    else if (ctl.mbr_pc)  mbr <= {{PAD_W{1'b0}}, pc};
    else if (ctl.mbr_inc) mbr <= mbr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ir <= '0;
    else if (ctl.ir_all)  ir <= mbr;
    else if (ctl.ir_addr) ir[ADDR_W-1:0] <= mbr[ADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) r1 <= '0;
    else if (ctl.r1_add) r1 <= r1 + mbr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ie <= 1'b0;
    else if (ctl.ie_clr) ie <= 1'b0;
    else if (ctl.ie_set) ie <= 1'b1;
  end

endmodule

// File: rtl/icyc_core.sv
module icyc_core
  import icyc_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 11,
  parameter int SAVE_ADDR = 0,
  parameter int HDL_ADDR  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              irq,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [1:0]        cyc,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] ir,
  output logic [DATA_W-1:0] r1,
  output logic              ie
);
  localparam int OP_LSB  = DATA_W - 4;
  localparam int IND_BIT = DATA_W - 5;

  state_t            state;
  ctl_t              ctl;
  logic [ADDR_W-1:0] mar;
  logic [DATA_W-1:0] mbr;
  logic [DATA_W-1:0] rword;
  logic              mbr_zero;
  logic              ld_fire;
  logic              ram_we;
  logic [ADDR_W-1:0] ram_wa;
  logic [DATA_W-1:0] ram_wd;

  assign ld_ready = (state == S_IDLE) && !run;
  assign ld_fire  = ld_valid && ld_ready;
  assign ram_we   = ld_fire || ctl.mem_wr;
  assign ram_wa   = ld_fire ? ld_addr : mar;
  assign ram_wd   = ld_fire ? ld_data : mbr;

  icyc_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .irq     (irq),
    .ie      (ie),
    .mbr_op  (mbr[DATA_W-1:OP_LSB]),
    .mbr_ind (mbr[IND_BIT]),
    .ir_op   (ir[DATA_W-1:OP_LSB]),
    .state   (state),
    .ctl     (ctl)
  );

  icyc_dpath #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .SAVE_ADDR (SAVE_ADDR),
    .HDL_ADDR  (HDL_ADDR)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctl),
    .rword    (rword),
    .pc       (pc),
    .mar      (mar),
    .mbr      (mbr),
    .ir       (ir),
    .r1       (r1),
    .ie       (ie),
    .mbr_zero (mbr_zero)
  );

  icyc_ram #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_wa),
    .wdata (ram_wd),
    .raddr (mar),
    .rword (rword)
  );

  assign mem_rd    = ctl.mem_rd;
  assign mem_wr    = ctl.mem_wr;
  assign mem_addr  = mar;
  assign mem_wdata = mbr;
  assign cyc       = cyc_of(state);

endmodule

// File: rtl/icyc_chk.sv
module icyc_chk #(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 11,
  parameter int HDL_ADDR = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_ready,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [1:0]        cyc,
  input logic [ADDR_W-1:0] pc,
  input logic [DATA_W-1:0] ir,
  input logic [DATA_W-1:0] r1,
  input logic              ie
);
  localparam logic [ADDR_W-1:0] HDL_A = ADDR_W'(HDL_ADDR);

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R10

  AST_WR_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (cyc == 2'd2 || cyc == 2'd3)); // R10

  AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ready |-> (!mem_rd && !mem_wr)); // R2

  AST_PC_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(pc) && $past(cyc) == 2'd0) |-> (pc == ADDR_W'($past(pc) + 1'b1))); // R3

  AST_IR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ir) |-> ($past(cyc) == 2'd0 || $past(cyc) == 2'd1)); // R4

  AST_R1_EXEC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(r1) |-> ($past(cyc) == 2'd2)); // R5

  AST_INT_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && cyc == 2'd3) |-> (pc == HDL_A && !ie)); // R9

endmodule

bind icyc_core icyc_chk #(
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W),
  .HDL_ADDR (HDL_ADDR)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ld_ready (ld_ready),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .cyc      (cyc),
  .pc       (pc),
  .ir       (ir),
  .r1       (r1),
  .ie       (ie)
);

// File: tb/icyc_core_test.sv
`timescale 1ns/1ps
module icyc_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic [10:0] ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic        irq = 1'b0;
  logic        mem_rd, mem_wr;
  logic [10:0] mem_addr, pc;
  logic [15:0] mem_wdata, ir, r1;
  logic [1:0]  cyc;
  logic        ie;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  icyc_core uut (
    .clk(clk), .rst_n(rst_n), .run(run), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_addr(ld_addr), .ld_data(ld_data), .irq(irq), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .cyc(cyc), .pc(pc), .ir(ir),
    .r1(r1), .ie(ie)
  );

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [15:0] mmem [2048];
  logic [10:0] mpc = '0, mmar = '0;
  logic [15:0] mmbr = '0, mir = '0, mr1 = '0;
  logic        mie = 1'b0;
  int          ph = 0;   // 0 idle, 1 fetch, 2 indirect, 3 execute, 4 interrupt
  int          st = 1;
  int          int_entries = 0;
  int          prev_ph = 0;
  logic [15:0] last_w43 = '0, last_w20 = '0, first_w0 = '0;
  bit          seen_w0 = 0;

  initial begin
    for (int i = 0; i < 2048; i++) mmem[i] = '0;
  end

  function automatic logic [15:0] prog(input int a);
    case (a)
      0:       return 16'h0000;  // no-op
      1:       return 16'h1040;  // add 0x40
      2:       return 16'h1841;  // add indirect via 0x41
      3:       return 16'h2043;  // inc-skip 0x43
      4:       return 16'h2043;  // inc-skip 0x43
      5:       return 16'h1040;  // add 0x40
      6:       return 16'h3020;  // branch-save 0x20
      'h21:    return 16'h4000;  // interrupt enable
      'h22:    return 16'h7000;  // unknown opcode
      'h40:    return 16'd5;
      'h41:    return 16'h0042;
      'h42:    return 16'd7;
      'h43:    return 16'hFFFE;
      default: return 16'h0000;
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [3:0] op;
      logic       erd, ewr, last, go;
      op  = mir[15:12];
      erd = (ph == 1 && st == 2) || (ph == 2 && st == 2) ||
            (ph == 3 && st == 2 && (op == 4'h1 || op == 4'h2));
      ewr = (ph == 3 && op == 4'h2 && st == 4) || (ph == 3 && op == 4'h3 && st == 2) ||
            (ph == 4 && st == 3);
      // compare
      check("R3", "pc", 32'(pc), 32'(mpc));
      check("R4", "ir", 32'(ir), 32'(mir));
      check("R5", "r1", 32'(r1), 32'(mr1));
      check("R8", "ie", 32'(ie), 32'(mie));
      check("R10", "cyc", 32'(cyc), (ph == 0) ? 32'd0 : 32'(ph - 1));
      check("R3", "mem_rd", 32'(mem_rd), 32'(erd));
      check("R10", "mem_wr", 32'(mem_wr), 32'(ewr));
      check("R2", "ld_ready", 32'(ld_ready), 32'(ph == 0 && !run));
      if (ewr) begin
        check("R10", "mem_addr", 32'(mem_addr), 32'(mmar));
        check("R10", "mem_wdata", 32'(mem_wdata), 32'(mmbr));
        if (mmar == 11'h43) last_w43 = mmbr;
        if (mmar == 11'h20) last_w20 = mmbr;
        if (mmar == 11'h00 && !seen_w0) begin first_w0 = mmbr; seen_w0 = 1; end
      end
      if (ph == 4 && prev_ph != 4) int_entries++;
      prev_ph = ph;
      // advance
      case (ph)
        0: begin
          if (ld_valid && !run) mmem[ld_addr] = ld_data;
          if (run) begin ph = 1; st = 1; end
        end
        1: begin
          if (st == 1) begin mmar = mpc; st = 2; end
          else if (st == 2) begin mmbr = mmem[mmar]; mpc = mpc + 1'b1; st = 3; end
          else begin mir = mmbr; ph = mir[11] ? 2 : 3; st = 1; end
        end
        2: begin
          if (st == 1) begin mmar = mir[10:0]; st = 2; end
          else if (st == 2) begin mmbr = mmem[mmar]; st = 3; end
          else begin mir[10:0] = mmbr[10:0]; ph = 3; st = 1; end
        end
        3: begin
          last = 1'b0;
          case (op)
            4'h1: case (st)
              1: mmar = mir[10:0];
              2: mmbr = mmem[mmar];
              default: begin mr1 = mr1 + mmbr; last = 1'b1; end
            endcase
            4'h2: case (st)
              1: mmar = mir[10:0];
              2: mmbr = mmem[mmar];
              3: mmbr = mmbr + 1'b1;
              default: begin
                mmem[mmar] = mmbr;
                if (mmbr == 16'h0) mpc = mpc + 1'b1;
                last = 1'b1;
              end
            endcase
            4'h3: case (st)
              1: begin mmar = mir[10:0]; mmbr = {5'b0, mpc}; end
              2: begin mmem[mmar] = mmbr; mpc = mir[10:0]; end
              default: begin mpc = mpc + 1'b1; last = 1'b1; end
            endcase
            default: last = 1'b1;
          endcase
          if (last) begin
            go = irq && mie;
            if (op == 4'h4) mie = 1'b1;
            ph = go ? 4 : 1;
            st = 1;
          end else st++;
        end
        default: begin
          if (st == 1) begin mmbr = {5'b0, mpc}; st = 2; end
          else if (st == 2) begin mmar = 11'd0; mpc = 11'd1; mie = 1'b0; st = 3; end
          else begin mmem[mmar] = mmbr; ph = 1; st = 1; end
        end
      endcase
    end
  end

  // drop the request once the first entry is seen
  initial begin
    wait (rst_n);
    wait (int_entries > 0);
    @(posedge clk); #1;
    irq = 1'b0;
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 during reset
    check("R1", "pc in reset", 32'(pc), 32'd0);
    check("R1", "r1 in reset", 32'(r1), 32'd0);
    check("R1", "strobes in reset", {30'd0, mem_rd, mem_wr}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "ir after reset", 32'(ir), 32'd0);
    check("R1", "ie after reset", 32'(ie), 32'd0);
    check("R1", "cyc after reset", 32'(cyc), 32'd0);
    check("R2", "ready while idle", 32'(ld_ready), 32'd1);
    // load program
    for (int a = 0; a < 128; a++) begin
      @(posedge clk); #1;
      ld_valid = 1'b1; ld_addr = 11'(a); ld_data = prog(a);
    end
    @(posedge clk); #1;
    ld_valid = 1'b0;
    irq = 1'b1;   // held pending from the start
    run = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    check("R2", "ready after start", 32'(ld_ready), 32'd0);
    run = 1'b0;
    repeat (300) @(posedge clk);
    @(negedge clk);
    check("R5", "accumulator total", 32'(r1), 32'd29);
    check("R6", "last write to 0x43", 32'(last_w43), 32'h0002);
    check("R7", "saved return address", 32'(last_w20), 32'h0007);
    check("R9", "first save to word 0", 32'(first_w0), 32'h0023);
    check("R9", "interrupt entries", 32'(int_entries), 32'd1);
    check("R8", "enable after handler", 32'(ie), 32'd1);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule